// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the sending side of an I2C bus controller that owns the bus. The host raises a one-cycle start request. The block then puts a START condition on the lines and waits with SCL held low. The host supplies each byte through a holding register. When a byte slot begins, the block copies the holding register into a separate shift register. That frees the holding register, so the host can queue the following byte while the current one is still on the wire. Each byte takes nine SCL clocks: eight data bits, most significant first, and then an acknowledge slot. In the acknowledge slot the block releases SDA and captures the slave's answer.

The block treats every byte the same way. The host builds the addressing itself. For 7-bit addressing it sends the address byte first. For 10-bit addressing it sends two address bytes first. If nothing is queued when an acknowledge clock ends, the block parks SCL low and raises a transfer-finished flag. It stays parked until a byte arrives or the host asks for a STOP or a repeated START. A NACK from the slave also parks the bus, and in that case a queued byte is not sent. Both lines are modelled as open-drain: the block only reports when it pulls each line low. The resolved SDA level comes back in on a separate input.

Top module: `i2c_master_tx`

## Requirements
- R1: After reset both line pull-downs are off, the busy, master and transmit flags are 0, the holding-empty flag is 1, and the transfer-finished flag and captured acknowledge bit are 0.
- R2: A start request while idle raises the busy, master and transmit flags from the next cycle. It then produces a START, meaning SDA falls while SCL is high. All three flags stay equal and stay 1 until the STOP has completed.
- R3: While the block is idle a byte write is ignored, and the holding-empty flag stays 1.
- R4: A byte write while the bus is owned clears the holding-empty flag in the next cycle. The flag sets again when that byte is copied into the shift register, which allows the next byte to be queued while the current one is still being sent.
- R5: Each byte goes out on eight SCL clocks, bit 7 first. SDA changes only while SCL is low, except for the START and STOP edges.
- R6: On the ninth clock the block releases SDA. It stores the SDA level seen at the end of the SCL high time as the acknowledge bit (0 = ACK, 1 = NACK).
- R7: If the holding register is empty when a ninth clock ends, SCL stays low and the transfer-finished flag reads 1 until a byte is written.
- R8: After a NACK, SCL stays low and a queued byte is not sent. Only a STOP or a repeated START moves the bus on.
- R9: A stop request takes effect after the current acknowledge clock. The sequence is SDA low with SCL low, then SCL high, then SDA rises. All status flags then clear and any queued byte is discarded (holding-empty = 1). A stop request wins over a queued byte and over a pending repeated START.
- R10: A start request while the bus is owned takes effect after the current acknowledge clock. The block releases SDA, raises SCL, then pulls SDA low, which is a START with no STOP in between. Queued bytes then continue.
- R11: Every SCL high time inside a byte lasts exactly 2*(clkDiv+1) clock cycles. Each bit consists of four equal quarter phases of clkDiv+1 cycles.
- R12: 7-bit writes are sent as {addr[6:0], 0}. 10-bit writes are sent as {11110, addr[9:8], 0} and then addr[7:0], followed by data. Each byte gets its own acknowledge slot.
- R13: A stop request while idle is ignored, and the block stays idle with both lines released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkDiv | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| startReq | input | 1 | One-cycle request for START or repeated START |
| stopReq | input | 1 | One-cycle request for STOP |
| dataWr | input | 1 | Write strobe for the holding register |
| dataIn | input | 8 | Byte to queue |
| sdaIn | input | 1 | Resolved SDA line level |
| sclPullLow | output | 1 | Block pulls SCL low |
| sdaPullLow | output | 1 | Block pulls SDA low |
| txEmpty | output | 1 | Holding register is free |
| txEnd | output | 1 | Ninth clock finished with nothing queued |
| busBusy | output | 1 | Bus is owned, from START until STOP ends |
| isMaster | output | 1 | Block is bus master |
| isTransmit | output | 1 | Block is in transmit mode |
| ackRcvd | output | 1 | Last acknowledge bit captured (0 = ACK) |

## Verification
The properties assume that start and stop requests are single-cycle pulses. They also assume that clkDiv changes only while the bus is idle, and that sdaIn is the wired-AND of the block's own SDA drive and a slave that pulls low only inside the acknowledge slot. The bench's slave model follows those rules. It drives its pull-down only between the falling edges that bound the ninth clock, and it changes clkDiv only between frames, after busBusy has returned to 0. Stimulus is generated only through the request and write ports, with one pulse per call.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RS0,
    ST_RS1,
    ST_START,
    ST_HOLD,
    ST_BIT,
    ST_STOP0,
    ST_STOP1,
    ST_STOP2
  } txState_e;

  // Strobes from the sequencer to the byte datapath.
  typedef struct packed {
    logic acceptWr;
    logic loadShift;
    logic shiftNext;
    logic sampleAck;
    logic flush;
    logic clearAck;
  } dpCtl_t;

endpackage

// File: rtl/i2c_tx_datapath.sv
module i2c_tx_datapath
  import i2c_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  output logic              tick,
  output logic              txEmpty,
  output logic              txBit,
  output logic              ackRcvd
);

  logic [DIV_W-1:0]  divCnt;
  logic [BYTE_W-1:0] holdReg;
  logic [BYTE_W-1:0] shiftReg;
  logic              emptyQ;
  logic              ackQ;

  // Quarter-phase pacing: one tick every clkDiv+1 cycles.
  assign tick = (divCnt >= clkDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Holding register and its empty flag; a host write wins over the copy.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      emptyQ  <= 1'b1;
    end else if (ctl.flush) begin
      emptyQ <= 1'b1;
    end else begin
      if (ctl.loadShift) begin
        emptyQ <= 1'b1;
      end
      if (ctl.acceptWr && dataWr) begin
        holdReg <= dataIn;
        emptyQ  <= 1'b0;
      end
    end
  end

  // Shift register, MSB leaves first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.loadShift) begin
      shiftReg <= holdReg;
    end else if (ctl.shiftNext) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
    end
  end

  // Acknowledge capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ <= 1'b0;
    end else if (ctl.clearAck) begin
      ackQ <= 1'b0;
    end else if (ctl.sampleAck) begin
      ackQ <= sdaIn;
    end
  end

  assign txEmpty = emptyQ;
  assign txBit   = shiftReg[BYTE_W-1];
  assign ackRcvd = ackQ;

endmodule

// File: rtl/i2c_tx_control.sv
module i2c_tx_control
  import i2c_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   tick,
  input  logic   startReq,
  input  logic   stopReq,
  input  logic   txEmpty,
  input  logic   txBit,
  input  logic   ackRcvd,
  output dpCtl_t ctl,
  output logic   sclPullLow,
  output logic   sdaPullLow,
  output logic   busBusy,
  output logic   txEnd
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  txState_e         state;
  logic [1:0]       quarter;
  logic [CNT_W-1:0] bitCnt;
  logic             sdaLowQ;
  logic             startPend;
  logic             stopPend;
  logic             afterByte;

  logic holdTick;
  logic nackWait;
  logic bitEnd;

  always_comb begin
    holdTick      = (state == ST_HOLD) && tick;
    nackWait      = afterByte && ackRcvd;
    bitEnd        = (state == ST_BIT) && tick && (quarter == 2'd3);
    ctl           = '0;
    ctl.acceptWr  = !(state inside {ST_IDLE, ST_STOP0, ST_STOP1, ST_STOP2});
    ctl.loadShift = holdTick && !stopPend && !startPend && !nackWait && !txEmpty;
    ctl.shiftNext = bitEnd && (bitCnt != ACK_SLOT);
    ctl.sampleAck = bitEnd && (bitCnt == ACK_SLOT);
    ctl.flush     = (state == ST_STOP2) && tick;
    ctl.clearAck  = (state == ST_IDLE) && startReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      quarter   <= '0;
      bitCnt    <= '0;
      sdaLowQ   <= 1'b0;
      startPend <= 1'b0;
      stopPend  <= 1'b0;
      afterByte <= 1'b0;
    end else begin
      if (state != ST_IDLE && startReq) startPend <= 1'b1;
      if (state != ST_IDLE && stopReq)  stopPend  <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state     <= ST_RS1;
            sdaLowQ   <= 1'b0;
            afterByte <= 1'b0;
          end
        end
        ST_RS0: begin
          if (tick) state <= ST_RS1;
        end
        ST_RS1: begin
          if (tick) begin
            state   <= ST_START;
            sdaLowQ <= 1'b1;
          end
        end
        ST_START: begin
          if (tick) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tick) begin
            if (stopPend) begin
              state     <= ST_STOP0;
              sdaLowQ   <= 1'b1;
              stopPend  <= 1'b0;
              startPend <= 1'b0;
            end else if (startPend) begin
              state     <= ST_RS0;
              sdaLowQ   <= 1'b0;
              startPend <= 1'b0;
              afterByte <= 1'b0;
            end else if (ctl.loadShift) begin
              state     <= ST_BIT;
              quarter   <= '0;
              bitCnt    <= '0;
              afterByte <= 1'b0;
            end
          end
        end
        ST_BIT: begin
          if (tick) begin
            quarter <= quarter + 2'd1;
            if (quarter == 2'd0) begin
              sdaLowQ <= (bitCnt == ACK_SLOT) ? 1'b0 : !txBit;
            end
            if (quarter == 2'd3) begin
              if (bitCnt == ACK_SLOT) begin
                state     <= ST_HOLD;
                afterByte <= 1'b1;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
        end
        ST_STOP0: begin
          if (tick) state <= ST_STOP1;
        end
        ST_STOP1: begin
          if (tick) begin
            state   <= ST_STOP2;
            sdaLowQ <= 1'b0;
          end
        end
        ST_STOP2: begin
          if (tick) begin
            state     <= ST_IDLE;
            startPend <= 1'b0;
            stopPend  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclPullLow = (state inside {ST_HOLD, ST_RS0, ST_STOP0}) ||
                      ((state == ST_BIT) && !quarter[1]);
  assign sdaPullLow = sdaLowQ;
  assign busBusy    = (state != ST_IDLE);
  assign txEnd      = (state == ST_HOLD) && afterByte && txEmpty;

endmodule

// File: rtl/i2c_master_tx.sv
module i2c_master_tx
  import i2c_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  output logic              txEmpty,
  output logic              txEnd,
  output logic              busBusy,
  output logic              isMaster,
  output logic              isTransmit,
  output logic              ackRcvd
);

  dpCtl_t ctl;
  logic   tick;
  logic   txBit;

  i2c_tx_datapath #(.DIV_W(DIV_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .clkDiv  (clkDiv),
    .dataWr  (dataWr),
    .dataIn  (dataIn),
    .sdaIn   (sdaIn),
    .ctl     (ctl),
    .tick    (tick),
    .txEmpty (txEmpty),
    .txBit   (txBit),
    .ackRcvd (ackRcvd)
  );

  i2c_tx_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .startReq   (startReq),
    .stopReq    (stopReq),
    .txEmpty    (txEmpty),
    .txBit      (txBit),
    .ackRcvd    (ackRcvd),
    .ctl        (ctl),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow),
    .busBusy    (busBusy),
    .txEnd      (txEnd)
  );

  // In this transmit-only master the ownership flags follow bus ownership.
  assign isMaster   = busBusy;
  assign isTransmit = busBusy;

endmodule

// File: rtl/i2c_master_tx_checker.sv
module i2c_master_tx_checker (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic stopReq,
  input logic dataWr,
  input logic sdaIn,
  input logic sclPullLow,
  input logic sdaPullLow,
  input logic txEmpty,
  input logic txEnd,
  input logic busBusy,
  input logic isMaster,
  input logic isTransmit,
  input logic ackRcvd
);

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busBusy |-> (!sclPullLow && !sdaPullLow));

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> $past(startReq));

  assert_status_agree_R2: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster == busBusy) && (isTransmit == busBusy));

  assert_idle_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busBusy |-> txEmpty);

  assert_ack_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackRcvd) |-> (sclPullLow && $past(sdaIn)));

  assert_end_holds_scl_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txEnd && !startReq && !stopReq && !dataWr) |=> sclPullLow);

  assert_idle_stop_ignored_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && stopReq && !startReq) |=> !busBusy);

endmodule

bind i2c_master_tx i2c_master_tx_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .stopReq    (stopReq),
  .dataWr     (dataWr),
  .sdaIn      (sdaIn),
  .sclPullLow (sclPullLow),
  .sdaPullLow (sdaPullLow),
  .txEmpty    (txEmpty),
  .txEnd      (txEnd),
  .busBusy    (busBusy),
  .isMaster   (isMaster),
  .isTransmit (isTransmit),
  .ackRcvd    (ackRcvd)
);

// File: tb/i2c_master_tx_bench.sv
`timescale 1ns/1ps
module i2c_master_tx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] clkDiv = 8'd0;
  logic       startReq = 1'b0;
  logic       stopReq = 1'b0;
  logic       dataWr = 1'b0;
  logic [7:0] dataIn = 8'd0;
  logic       sdaIn;
  logic       sclPullLow, sdaPullLow, txEmpty, txEnd, busBusy, isMaster, isTransmit, ackRcvd;

  logic slvLow = 1'b0;
  logic sclLine, sdaLine;
  assign sclLine = !sclPullLow;
  assign sdaLine = !(sdaPullLow || slvLow);
  assign sdaIn   = sdaLine;

  int checkCnt = 0;
  int failCnt  = 0;

  int startCnt = 0, stopCnt = 0, rxCount = 0, bitIdx = 0;
  int highLen = 0, hiErr = 0, riseCnt = 0, nackAt = -1;
  logic [7:0] rxShift = 8'd0;
  logic [7:0] rxBytes [0:63];
  logic prevScl = 1'b1, prevSda = 1'b1;
  logic [7:0] frame [0:7];

  i2c_master_tx #(.DIV_W(8)) u_i2c_master_tx (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .startReq(startReq), .stopReq(stopReq),
    .dataWr(dataWr), .dataIn(dataIn), .sdaIn(sdaIn), .sclPullLow(sclPullLow),
    .sdaPullLow(sdaPullLow), .txEmpty(txEmpty), .txEnd(txEnd), .busBusy(busBusy),
    .isMaster(isMaster), .isTransmit(isTransmit), .ackRcvd(ackRcvd)
  );

  always #10 clk = ~clk;

  // Slave model and line monitor, sampled on the falling clock edge.
  always @(negedge clk) begin
    if (!rstN) begin
      prevScl = 1'b1; prevSda = 1'b1; bitIdx = 0; slvLow = 1'b0;
    end else begin
      if (sclLine && prevScl && (sdaLine != prevSda)) begin
        if (!sdaLine) begin startCnt++; bitIdx = 0; end
        else stopCnt++;
      end
      if (sclLine && !prevScl) begin
        riseCnt++;
        highLen = 1;
        if (bitIdx < 8) rxShift = {rxShift[6:0], sdaLine};
        bitIdx++;
      end else if (sclLine) begin
        highLen++;
      end
      if (!sclLine && prevScl && bitIdx > 0) begin
        if (highLen != 2 * (int'(clkDiv) + 1)) hiErr++;
        if (bitIdx == 8) begin
          rxBytes[rxCount % 64] = rxShift;
          slvLow = (rxCount != nackAt);
        end else if (bitIdx == 9) begin
          slvLow = 1'b0;
          rxCount++;
          bitIdx = 0;
        end
      end
      prevScl = sclLine;
      prevSda = sdaLine;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    startReq = 1'b1; step(); startReq = 1'b0;
  endtask

  task automatic pulseStop();
    stopReq = 1'b1; step(); stopReq = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b);
    while (!txEmpty) step();
    dataIn = b; dataWr = 1'b1; step(); dataWr = 1'b0;
    checkEq("R4 write clears holding-empty", int'(txEmpty), 0);
  endtask

  task automatic waitTxEnd();
    while (!txEnd) step();
  endtask

  task automatic waitIdle();
    while (busBusy) step();
  endtask

  task automatic waitStart(input int s0);
    while (startCnt == s0) step();
  endtask

  task automatic runFrame(input int n);
    int base, s0, st, r;
    base = rxCount; s0 = startCnt; st = stopCnt;
    pulseStart();
    checkEq("R2 busBusy after start", int'(busBusy), 1);
    checkEq("R2 master flag", int'(isMaster), 1);
    checkEq("R2 transmit flag", int'(isTransmit), 1);
    waitStart(s0);
    for (int k = 0; k < n; k++) begin
      writeByte(frame[k]);
      if (k == 1) checkEq("R4 second byte queued during first", rxCount, base);
    end
    waitTxEnd();
    checkEq("R7 all bytes done at txEnd", rxCount, base + n);
    for (int k = 0; k < n; k++) checkEq("R5 R12 byte content", int'(rxBytes[(base + k) % 64]), int'(frame[k]));
    checkEq("R6 ack captured", int'(ackRcvd), 0);
    checkEq("R5 no stray stop", stopCnt, st);
    checkEq("R5 single start", startCnt, s0 + 1);
    r = riseCnt;
    repeat (40) step();
    checkEq("R7 SCL parked", riseCnt, r);
    checkEq("R7 SCL pulled low", int'(sclPullLow), 1);
    checkEq("R7 txEnd held", int'(txEnd), 1);
    checkEq("R11 SCL high time", hiErr, 0);
  endtask

  task automatic stopFrame();
    int st;
    st = stopCnt;
    pulseStop();
    waitIdle();
    step();
    checkEq("R9 stop seen", stopCnt, st + 1);
    checkEq("R9 busy cleared", int'(busBusy), 0);
    checkEq("R9 master cleared", int'(isMaster), 0);
    checkEq("R9 holding empty", int'(txEmpty), 1);
    checkEq("R9 lines released", int'(sclPullLow || sdaPullLow), 0);
  endtask

  initial begin
    int base, s0, st, r;
    repeat (4) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    checkEq("R1 scl released", int'(sclPullLow), 0);
    checkEq("R1 sda released", int'(sdaPullLow), 0);
    checkEq("R1 busy", int'(busBusy), 0);
    checkEq("R1 master", int'(isMaster), 0);
    checkEq("R1 transmit", int'(isTransmit), 0);
    checkEq("R1 empty", int'(txEmpty), 1);
    checkEq("R1 txEnd", int'(txEnd), 0);
    checkEq("R1 ack", int'(ackRcvd), 0);

    // R3 idle write ignored
    dataIn = 8'h5A; dataWr = 1'b1; step(); dataWr = 1'b0;
    checkEq("R3 idle write ignored", int'(txEmpty), 1);

    // R13 idle stop ignored
    pulseStop();
    repeat (5) step();
    checkEq("R13 idle stop busy", int'(busBusy), 0);
    checkEq("R13 idle stop no condition", stopCnt, 0);
    checkEq("R13 lines released", int'(sclPullLow || sdaPullLow), 0);

    // 7-bit writes over several divider settings
    for (int d = 0; d < 3; d++) begin
      clkDiv = 8'(d);
      frame[0] = {7'(8'h50 + d), 1'b0};
      for (int k = 1; k < 4; k++) frame[k] = 8'((d * 53 + k * 29 + 7) & 255);
      runFrame(4);
      stopFrame();
    end
    clkDiv = 8'd1;
    frame[0] = 8'hA0; frame[1] = 8'hFF; frame[2] = 8'h00; frame[3] = 8'h81;
    runFrame(4);
    stopFrame();

    // R12 10-bit address 0x2A5
    clkDiv = 8'd1;
    frame[0] = {5'b11110, 2'b10, 1'b0};
    frame[1] = 8'hA5;
    frame[2] = 8'h3C;
    checkEq("R12 10-bit prefix", int'(frame[0]), 8'hF4);
    runFrame(3);
    stopFrame();

    // R8 NACK on second byte, third byte queued but held
    clkDiv = 8'd1;
    base = rxCount; s0 = startCnt;
    nackAt = base + 1;
    pulseStart();
    waitStart(s0);
    writeByte(8'hA2);
    writeByte(8'h11);
    writeByte(8'h22);
    while (rxCount != base + 2) step();
    r = riseCnt;
    repeat (40) step();
    checkEq("R6 nack captured", int'(ackRcvd), 1);
    checkEq("R8 no byte after nack", rxCount, base + 2);
    checkEq("R8 SCL parked after nack", riseCnt, r);
    checkEq("R8 queued byte kept", int'(txEmpty), 0);
    checkEq("R8 SCL low after nack", int'(sclPullLow), 1);
    stopFrame();
    checkEq("R9 queued byte discarded", rxCount, base + 2);
    nackAt = -1;

    // R10 repeated start
    clkDiv = 8'd2;
    base = rxCount; s0 = startCnt;
    pulseStart();
    waitStart(s0);
    writeByte(8'hB4);
    waitTxEnd();
    s0 = startCnt; st = stopCnt;
    pulseStart();
    writeByte(8'hB5);
    writeByte(8'h42);
    waitTxEnd();
    checkEq("R10 repeated start seen", startCnt, s0 + 1);
    checkEq("R10 no stop between", stopCnt, st);
    checkEq("R10 busy kept", int'(busBusy), 1);
    checkEq("R10 bytes after restart", rxCount, base + 3);
    checkEq("R10 address after restart", int'(rxBytes[(base + 1) % 64]), 8'hB5);
    checkEq("R10 data after restart", int'(rxBytes[(base + 2) % 64]), 8'h42);
    checkEq("R11 SCL high time", hiErr, 0);
    stopFrame();

    // R9 stop wins over queued byte
    clkDiv = 8'd0;
    base = rxCount; s0 = startCnt; st = stopCnt;
    pulseStart();
    waitStart(s0);
    writeByte(8'hC6);
    writeByte(8'h99);
    pulseStop();
    waitIdle();
    step();
    checkEq("R9 stop priority byte count", rxCount, base + 1);
    checkEq("R9 stop priority stop seen", stopCnt, st + 1);
    checkEq("R9 stop priority empty", int'(txEmpty), 1);
    checkEq("R9 first byte sent", int'(rxBytes[base % 64]), 8'hC6);

    summary();
    $finish;
  end

endmodule